// File: doc/BRIEF.md
# Pulse Period Measurement Timer

This block is an 8-bit down-counting timer for measuring the period of an external signal. The counter steps down by one on each cycle in which a prescaler strobe is high. A measurement input is synchronized and watched for an active edge. On each active edge the block stores a snapshot of the count in a capture buffer, reloads the counter and raises an edge flag. If the counter steps past zero, it reloads and raises an underflow flag. Software computes the pulse period from the reload value, the captured count and the number of underflows it has seen.

The bus side has three registers. The control/status register holds the run and polarity bits and the two sticky flags. Writes to the timer register set the reload value, and reads from it return the capture buffer. The interrupt register holds the pending request.

The capture buffer is locked while it holds a result that has not been read. An edge that arrives while the buffer is locked still reloads the counter and sets the flag, but its count is dropped. A single-cycle read strobe on the timer register releases the lock.

Top module: `ppm_timer`

## Requirements
- R1: After reset the counter and the reload register hold 0Fh, the capture buffer holds 00h, run and polarity are 0, and the edge flag, the underflow flag and the interrupt request are all 0.
- R2: The register is selected by `addr_i`: 0 = control/status, 1 = timer, 2 = interrupt. In the control/status register, bit 0 is run, bit 1 is polarity, bit 2 is the edge flag and bit 3 is the underflow flag. A write to the timer register sets the reload value, and a read of it returns the capture buffer. In the interrupt register, bit 0 is the request. Unused read bits are 0.
- R3: While run is 1, the counter decrements by one on each clock with `tick_i` high. While run is 0, the count holds and input edges are ignored: no capture, no reload and no flag is set.
- R4: `meas_i` passes through two synchronizer flops before edge detection. With polarity 0 the active edge is rising, and with polarity 1 it is falling. An active edge reloads the counter from the reload register and sets the edge flag.
- R5: A tick that arrives while the count is 00h reloads the counter from the reload register and sets the underflow flag.
- R6: The captured value depends on `tick_i` in the cycle the edge acts. If `tick_i` is high, the buffer takes the count before that tick. If `tick_i` is low, it takes the count that would follow, which is count-1, or the reload value when the count is 00h.
- R7: Once the buffer holds a result, later edges leave it unchanged until a read strobe (`rd_en_i` with address 1) arrives. If a capture and a read strobe fall in the same cycle, the capture loads the buffer and the buffer stays locked.
- R8: If an active edge and an underflow fall in the same cycle, both flags are set and the counter reloads.
- R9: Writing 0 to a flag bit clears that flag, and writing 1 leaves it as it was, so each flag can be cleared without touching the other. If hardware sets a flag in the same cycle as a clear, the set wins.
- R10: `irq_o` is set by an active edge or an underflow. It is cleared by `irq_ack_i` or by writing 0 to bit 0 of the interrupt register, and writing 1 there leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaler underflow strobe |
| meas_i | input | 1 | Asynchronous measurement input |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 2 | Register select, shared by reads and writes |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; with address 1 it releases the capture lock |
| rdata_o | output | 8 | Read data of the selected register |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that reset is held for at least one clock. They also treat `tick_i`, the bus strobes and `irq_ack_i` as synchronous single-cycle-valid signals, while `meas_i` may change at any time. The stimulus changes every synchronous input half a cycle away from the active edge and holds `meas_i` steady for several cycles between transitions. Because of this, each edge passes cleanly through the synchronizer, and the cycle in which the edge acts can be predicted as the third rising clock after the change. The tick-sensitive capture and the simultaneous edge-and-underflow cases rely on that fixed latency.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    localparam int unsigned CNT_W_DEF  = 8;
    localparam int unsigned SYNC_DEF   = 2;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TMR  = 2'd1,
        REG_IRQ  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned BIT_RUN  = 0;
    localparam int unsigned BIT_POL  = 1;
    localparam int unsigned BIT_EDGE = 2;
    localparam int unsigned BIT_UNF  = 3;
    localparam int unsigned BIT_IRQ  = 0;

    typedef struct packed {
        logic run;
        logic pol;
    } ctrl_t;

    typedef struct packed {
        logic edge_f;
        logic unf_f;
        logic irq;
    } stat_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_reload;
        logic wr_irq;
        logic unlock;
    } bus_dec_t;

    function automatic bus_dec_t decode_bus(input logic wr_en, input logic rd_en,
                                            input logic [1:0] addr);
        bus_dec_t d;
        d.wr_ctrl   = wr_en && (reg_sel_e'(addr) == REG_CTRL);
        d.wr_reload = wr_en && (reg_sel_e'(addr) == REG_TMR);
        d.wr_irq    = wr_en && (reg_sel_e'(addr) == REG_IRQ);
        d.unlock    = rd_en && (reg_sel_e'(addr) == REG_TMR);
        return d;
    endfunction

endpackage

// File: rtl/ppm_edge_sync.sv
module ppm_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic falling,
    input  logic enable,
    output logic evt
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    always_comb begin
        if (falling) evt = enable & prev_q & ~sync_q[LAST];
        else         evt = enable & ~prev_q & sync_q[LAST];
    end
endmodule

// File: rtl/ppm_down_counter.sv
module ppm_down_counter #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] INIT = 'h0F
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic [W-1:0] sample_val,
    output logic         unf_evt
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic [W-1:0] r);
        return (c == ZERO) ? r : (c - ONE);
    endfunction

    logic [W-1:0] cnt_q;

    assign unf_evt    = run & tick & (cnt_q == ZERO);
    assign sample_val = tick ? cnt_q : step(cnt_q, reload_val);
    assign count      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= INIT;
        end else if (run) begin
            if (load)      cnt_q <= reload_val;
            else if (tick) cnt_q <= step(cnt_q, reload_val);
        end
    end
endmodule

// File: rtl/ppm_capture.sv
module ppm_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt,
    input  logic [W-1:0] val,
    input  logic         unlock,
    output logic [W-1:0] buf_q,
    output logic         locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            locked <= 1'b0;
        end else if (evt && (!locked || unlock)) begin
            buf_q  <= val;
            locked <= 1'b1;
        end else if (unlock) begin
            locked <= 1'b0;
        end
    end
endmodule

// File: rtl/ppm_flags.sv
module ppm_flags (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_edge,
    input  logic          set_unf,
    input  logic          wr_ctrl,
    input  logic          wd_edge,
    input  logic          wd_unf,
    input  logic          wr_irq,
    input  logic          wd_irq,
    input  logic          ack,
    output ppm_pkg::stat_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (set_edge)                st.edge_f <= 1'b1;
            else if (wr_ctrl && !wd_edge) st.edge_f <= 1'b0;

            if (set_unf)                 st.unf_f <= 1'b1;
            else if (wr_ctrl && !wd_unf)  st.unf_f <= 1'b0;

            if (set_edge || set_unf)               st.irq <= 1'b1;
            else if (ack || (wr_irq && !wd_irq))    st.irq <= 1'b0;
        end
    end
endmodule

// File: rtl/ppm_timer.sv
module ppm_timer #(
    parameter int unsigned CNT_W       = ppm_pkg::CNT_W_DEF,
    parameter int unsigned SYNC_STAGES = ppm_pkg::SYNC_DEF,
    parameter logic [CNT_W-1:0] RELOAD_INIT = 'h0F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             meas_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             rd_en_i,
    output logic [CNT_W-1:0] rdata_o,
    input  logic             irq_ack_i,
    output logic             irq_o
);
    import ppm_pkg::*;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    bus_dec_t         dec;
    logic             edge_evt;
    logic             unf_evt;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] sample_val;
    logic [CNT_W-1:0] cap_buf;
    logic             cap_locked;
    stat_t            st;

    assign dec = decode_bus(wr_en_i, rd_en_i, addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= RELOAD_INIT;
        end else begin
            if (dec.wr_ctrl) begin
                ctrl_q.run <= wdata_i[BIT_RUN];
                ctrl_q.pol <= wdata_i[BIT_POL];
            end
            if (dec.wr_reload) reload_q <= wdata_i;
        end
    end

    ppm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (meas_i),
        .falling(ctrl_q.pol),
        .enable (ctrl_q.run),
        .evt    (edge_evt)
    );

    ppm_down_counter #(.W(CNT_W), .INIT(RELOAD_INIT)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .tick      (tick_i),
        .load      (edge_evt),
        .reload_val(reload_q),
        .count     (count),
        .sample_val(sample_val),
        .unf_evt   (unf_evt)
    );

    ppm_capture #(.W(CNT_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .evt   (edge_evt),
        .val   (sample_val),
        .unlock(dec.unlock),
        .buf_q (cap_buf),
        .locked(cap_locked)
    );

    ppm_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_edge(edge_evt),
        .set_unf (unf_evt),
        .wr_ctrl (dec.wr_ctrl),
        .wd_edge (wdata_i[BIT_EDGE]),
        .wd_unf  (wdata_i[BIT_UNF]),
        .wr_irq  (dec.wr_irq),
        .wd_irq  (wdata_i[BIT_IRQ]),
        .ack     (irq_ack_i),
        .st      (st)
    );

    always_comb begin
        rdata_o = '0;
        case (reg_sel_e'(addr_i))
            REG_CTRL: begin
                rdata_o[BIT_RUN]  = ctrl_q.run;
                rdata_o[BIT_POL]  = ctrl_q.pol;
                rdata_o[BIT_EDGE] = st.edge_f;
                rdata_o[BIT_UNF]  = st.unf_f;
            end
            REG_TMR:  rdata_o = cap_buf;
            REG_IRQ:  rdata_o[BIT_IRQ] = st.irq;
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o = st.irq;
endmodule

// File: rtl/ppm_timer_chk.sv
module ppm_timer_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         tick,
    input logic         edge_evt,
    input logic         unf_evt,
    input logic         unlock,
    input logic [W-1:0] count,
    input logic [W-1:0] reload,
    input logic [W-1:0] cap_buf,
    input logic         locked,
    input logic         edge_f,
    input logic         unf_f,
    input logic         irq
);
    localparam logic [W-1:0] ZERO = '0;

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !edge_evt && count != ZERO) |=> (count == $past(count) - 1'b1));

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count == ZERO) |=> (count == $past(reload) && unf_f));

    // R4
    edge_flag_chk: assert property (@(posedge clk) disable iff (rst)
        edge_evt |=> (edge_f && count == $past(reload)));

    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !unlock) |=> $stable(cap_buf));

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(edge_evt || unf_evt));
endmodule

bind ppm_timer ppm_timer_chk #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .tick    (tick_i),
    .edge_evt(edge_evt),
    .unf_evt (unf_evt),
    .unlock  (dec.unlock),
    .count   (count),
    .reload  (reload_q),
    .cap_buf (cap_buf),
    .locked  (cap_locked),
    .edge_f  (st.edge_f),
    .unf_f   (st.unf_f),
    .irq     (st.irq)
);

// File: tb/test_ppm_timer.sv
module test_ppm_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       meas_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wdata_i = 8'h00;
    logic       rd_en_i = 1'b0;
    logic [7:0] rdata_o;
    logic       irq_ack_i = 1'b0;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ppm_timer i_ppm_timer (
        .clk(clk), .rst(rst), .tick_i(tick_i), .meas_i(meas_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rd_en_i(rd_en_i), .rdata_o(rdata_o),
        .irq_ack_i(irq_ack_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit strobe, output logic [7:0] v);
        @(negedge clk);
        addr_i = a; rd_en_i = strobe;
        #1 v = rdata_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic meas_slow(input logic lvl);
        @(negedge clk); meas_i = lvl;
        repeat (6) @(negedge clk);
    endtask

    // tick held high from the input change until the edge acts (third posedge)
    task automatic meas_fast(input logic lvl);
        @(negedge clk); tick_i = 1'b1; meas_i = lvl;
        repeat (3) @(posedge clk);
        @(negedge clk); tick_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, 1'b0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, 1'b0, v); check("R1 buffer", v, 8'h00);
        rd(2'd2, 1'b0, v); check("R1 irq reg", v, 8'h00);
        check("R1 irq pin", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_tick_low;
        logic [7:0] v;
        wr(2'd0, 8'h01);
        ticks(3);                     // 0F -> 0C
        meas_slow(1'b1);              // capture next count 0B
        rd(2'd0, 1'b0, v); check("R4 R2 edge flag", v, 8'h05);
        check("R10 irq on edge", {7'd0, irq_o}, 8'h01);
        rd(2'd1, 1'b1, v); check("R6 tick low capture", v, 8'h0B);
    endtask

    task automatic t_tick_high;
        logic [7:0] v;
        meas_slow(1'b0);
        meas_fast(1'b1);              // 0F,0E,0D -> capture 0D
        rd(2'd1, 1'b1, v); check("R6 tick high capture", v, 8'h0D);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        meas_slow(1'b0); meas_slow(1'b1);      // capture 0E, locked
        ticks(4);
        meas_slow(1'b0); meas_slow(1'b1);      // discarded
        rd(2'd1, 1'b0, v); check("R7 kept while locked", v, 8'h0E);
        rd(2'd1, 1'b1, v);                     // unlock
        ticks(4);                              // 0F -> 0B
        meas_slow(1'b0); meas_slow(1'b1);      // capture 0A
        rd(2'd1, 1'b0, v); check("R7 new after read", v, 8'h0A);
        meas_slow(1'b0);
        @(negedge clk); meas_i = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); addr_i = 2'd1; rd_en_i = 1'b1;
        @(posedge clk);
        @(negedge clk); rd_en_i = 1'b0;        // capture 0E wins, stays locked
        ticks(1);
        meas_slow(1'b0); meas_slow(1'b1);      // discarded (would be 0D)
        rd(2'd1, 1'b0, v); check("R7 same-cycle capture", v, 8'h0E);
        rd(2'd1, 1'b1, v);
    endtask

    task automatic t_pol;
        logic [7:0] v;
        wr(2'd0, 8'h0F);                       // run, falling edges
        ticks(2);                              // 0F -> 0D
        meas_slow(1'b0);                       // capture 0C
        rd(2'd1, 1'b1, v); check("R4 falling edge", v, 8'h0C);
        ticks(1);
        meas_slow(1'b1);                       // rising ignored
        rd(2'd1, 1'b0, v); check("R4 rising ignored", v, 8'h0C);
        wr(2'd0, 8'h0D);
    endtask

    task automatic t_underflow;
        logic [7:0] v;
        wr(2'd1, 8'h03);
        meas_slow(1'b0); meas_slow(1'b1);      // reload to 03
        rd(2'd1, 1'b1, v);
        wr(2'd0, 8'h01); wr(2'd2, 8'h00);
        ticks(3);
        rd(2'd0, 1'b0, v); check("R5 no flag at zero", v, 8'h01);
        ticks(1);
        rd(2'd0, 1'b0, v); check("R5 underflow flag", v, 8'h09);
        check("R10 irq on underflow", {7'd0, irq_o}, 8'h01);
        @(negedge clk); irq_ack_i = 1'b1;
        @(negedge clk); irq_ack_i = 1'b0;
        check("R10 ack clears", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_both;
        logic [7:0] v;
        wr(2'd0, 8'h01);
        meas_slow(1'b0);
        ticks(1);                              // 03 -> 02
        meas_fast(1'b1);                       // 01, 00, edge+underflow
        rd(2'd1, 1'b1, v); check("R8 capture at zero", v, 8'h00);
        rd(2'd0, 1'b0, v); check("R8 both flags", v, 8'h0D);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        wr(2'd0, 8'h05);
        rd(2'd0, 1'b0, v); check("R9 clear underflow only", v, 8'h05);
        wr(2'd0, 8'h09);
        rd(2'd0, 1'b0, v); check("R9 clear edge only", v, 8'h01);
    endtask

    task automatic t_irq_sw;
        logic [7:0] v;
        wr(2'd2, 8'h01);
        rd(2'd2, 1'b0, v); check("R10 write 1 keeps", v, 8'h01);
        wr(2'd2, 8'h00);
        rd(2'd2, 1'b0, v); check("R10 write 0 clears", v, 8'h00);
    endtask

    task automatic t_stop;
        logic [7:0] v;
        wr(2'd0, 8'h00);
        ticks(5);
        meas_slow(1'b0); meas_slow(1'b1);
        rd(2'd1, 1'b0, v); check("R3 no capture stopped", v, 8'h00);
        rd(2'd0, 1'b0, v); check("R3 no flag stopped", v, 8'h00);
        check("R3 no irq stopped", {7'd0, irq_o}, 8'h00);
        wr(2'd0, 8'h01);
        meas_slow(1'b0); meas_slow(1'b1);      // count held at 03 -> capture 02
        rd(2'd1, 1'b1, v); check("R3 count held", v, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tick_low();
        t_tick_high();
        t_lock();
        t_pol();
        t_underflow();
        t_both();
        t_clear();
        t_irq_sw();
        t_stop();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule